// File: doc/BRIEF.md
# Per-Hart Interrupt Delivery Controller

This block routes wired interrupt sources to a set of harts. Each source owns a target word. The word names the hart that should receive the source and the priority the source carries. Each hart owns a delivery context that holds a delivery enable, a force flag and a priority threshold. For every hart the block looks at the sources that are pending, enabled and routed to that hart. It picks the most urgent one, compares its priority against the hart's threshold, and drives a registered external interrupt line to the hart.

Software reads the context's top register to see which source won without changing any state. A read of the claim register returns the same value and also emits a one-cycle clear-pending strobe that carries the winning source number. The logic that keeps the pending bits outside this block uses that strobe to drop the source. A handler keeps claiming until the claim register returns zero. The pending-and-enabled vector comes in from outside the block. Accesses arrive over a simple request bus with a 16-bit byte address, and read data comes back one cycle after the request.

Top module: `dlv_delivery_ctrl`

## Requirements
- R1: After reset every target word reads 0x00000001 (hart index 0, priority 1). Every context register reads 0, and all hart interrupt lines are low.
- R2: The target word of source i (1..N_SRC) sits at byte address 0x3004 + (i-1)*4. Bits 31:18 hold the hart index and bits 7:0 hold the priority. Bits 17:8 read as zero whatever was written.
- R3: For each hart, the top register (context base + 0x18) reports the winner among the pending sources whose hart index equals that hart. The lowest numeric priority wins, a priority field of 0 counts as 1, and on a tie the lower source number wins. The source number goes in bits 25:16 and the effective priority in bits 7:0.
- R4: The threshold (context base + 0x08, bits 7:0) admits a winner only when its priority is strictly below a nonzero threshold. A threshold of 0 admits every priority, and a threshold of 1 admits none. A hart with no admitted winner reads top as 0.
- R5: Context h starts at 0x4000 + h*32. Delivery enable is bit 0 at +0x00 and force is bit 0 at +0x04. The hart line is a register that is high exactly when delivery is 1 and either top is nonzero or force is 1.
- R6: A read of the claim register (context base + 0x1C) returns the top value sampled in the request cycle. When that value is nonzero, clr_valid pulses for one cycle, alongside bus_rvalid, with clr_src equal to the returned source number. There is one pulse per read.
- R7: A claim read that returns zero produces no clear strobe and sets that hart's force bit to 0.
- R8: The following read as zero and ignore writes: target words of sources above N_SRC, address 0x3000, contexts at or above N_HART, and unused context offsets. Writes to the top and claim registers change nothing.
- R9: bus_rvalid is high in the cycle after each read request and only then, with bus_rdata valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| src_pend | input | N_SRC | Pending-and-enabled vector, bit i is source i (indices N_SRC..1) |
| hart_irq | output | N_HART | External interrupt line per hart |
| clr_valid | output | 1 | Clear-pending strobe from a claim |
| clr_src | output | clog2(N_SRC+1) | Source number to clear |

## Verification
The arbitration input can change in the same cycle that a claim read is sampled. The bench raises a more urgent source on the pending vector in the very cycle it issues the claim request. It expects the claim to return the new source, and it expects the clear strobe to name that source and not the one that was winning a cycle earlier. A scoreboard compares each returned word and each clear strobe against a model of the pending vector. The model drops a bit only when the design's clear strobe is observed.

// File: rtl/dlv_pkg.sv
package dlv_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 32;
  localparam int HIDX_W   = 14;
  localparam int HIDX_LSB = 18;
  localparam int PRIO_W   = 8;
  localparam int ID_LSB   = 16;
  localparam logic [4:0] OFF_DLV = 5'h00;
  localparam logic [4:0] OFF_FRC = 5'h04;
  localparam logic [4:0] OFF_THR = 5'h08;
  localparam logic [4:0] OFF_TOP = 5'h18;
  localparam logic [4:0] OFF_CLM = 5'h1C;
endpackage

// File: rtl/dlv_targets.sv
module dlv_targets
  import dlv_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int SRC_W = $clog2(N_SRC + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [SRC_W-1:0]          wr_src,
  input  logic [DATA_W-1:0]         wdata,
  output logic [N_SRC*HIDX_W-1:0]   hart_flat,
  output logic [N_SRC*PRIO_W-1:0]   prio_flat
);
  // one routing/priority pair per source; slot s-1 belongs to source s
  for (genvar s = 1; s <= N_SRC; s++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        hart_flat[(s-1)*HIDX_W +: HIDX_W] <= '0;
        prio_flat[(s-1)*PRIO_W +: PRIO_W] <= PRIO_W'(1);
      end else if (wr_en && wr_src == SRC_W'(s)) begin
        hart_flat[(s-1)*HIDX_W +: HIDX_W] <= wdata[HIDX_LSB +: HIDX_W];
        prio_flat[(s-1)*PRIO_W +: PRIO_W] <= wdata[PRIO_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dlv_ctx.sv
module dlv_ctx
  import dlv_pkg::*;
#(
  parameter int N_SRC   = 8,
  parameter int SRC_W   = $clog2(N_SRC + 1),
  parameter int HART_ID = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_SRC:1]          pend,
  input  logic [N_SRC*HIDX_W-1:0] hart_flat,
  input  logic [N_SRC*PRIO_W-1:0] prio_flat,
  input  logic                    wr_dlv,
  input  logic                    wr_frc,
  input  logic                    wr_thr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic                    claim,
  output logic                    dlv_o,
  output logic                    frc_o,
  output logic [PRIO_W-1:0]       thr_o,
  output logic [DATA_W-1:0]       top_o,
  output logic                    irq_o
);
  logic [SRC_W-1:0]  best_id;
  logic [PRIO_W:0]   best_p;
  logic [PRIO_W-1:0] eff;
  logic              admit;

  // linear scan: strict compare keeps the lower source number on ties
  always_comb begin
    best_id = '0;
    best_p  = {1'b1, {PRIO_W{1'b0}}};
    eff     = '0;
    for (int s = 1; s <= N_SRC; s++) begin
      eff = prio_flat[(s-1)*PRIO_W +: PRIO_W];
      if (eff == '0) eff = PRIO_W'(1);
      if (pend[s] && hart_flat[(s-1)*HIDX_W +: HIDX_W] == HIDX_W'(HART_ID)
          && {1'b0, eff} < best_p) begin
        best_p  = {1'b0, eff};
        best_id = SRC_W'(s);
      end
    end
    admit = (best_id != '0) && (thr_o == '0 || best_p[PRIO_W-1:0] < thr_o);
    top_o = admit ? ((DATA_W'(best_id) << ID_LSB) | DATA_W'(best_p[PRIO_W-1:0])) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_o <= 1'b0;
      frc_o <= 1'b0;
      thr_o <= '0;
      irq_o <= 1'b0;
    end else begin
      if (wr_dlv) dlv_o <= wdata[0];
      if (wr_thr) thr_o <= wdata[PRIO_W-1:0];
      if (wr_frc)                       frc_o <= wdata[0];
      else if (claim && top_o == '0)    frc_o <= 1'b0;
      irq_o <= dlv_o && (top_o != '0 || frc_o);
    end
  end

  // R5: the line only rises for a context whose delivery was enabled
  p_irq_needs_dlv_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(dlv_o));
  // R7: an empty claim leaves force cleared
  p_empty_claim_drops_force_r7: assert property (@(posedge clk) disable iff (rst)
    (claim && top_o == '0 && !wr_frc) |=> !frc_o);
  // R4: a reported winner always passes a nonzero threshold
  p_threshold_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (top_o != '0 && thr_o != '0) |-> (top_o[PRIO_W-1:0] < thr_o));
endmodule

// File: rtl/dlv_delivery_ctrl.sv
module dlv_delivery_ctrl
  import dlv_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int N_HART = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_req,
  input  logic                         bus_we,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  output logic                         bus_rvalid,
  input  logic [N_SRC:1]               src_pend,
  output logic [N_HART-1:0]            hart_irq,
  output logic                         clr_valid,
  output logic [$clog2(N_SRC+1)-1:0]   clr_src
);
  localparam int SRC_W = $clog2(N_SRC + 1);
  localparam int TGT_W = 10;
  localparam int CTX_W = 9;

  logic [N_SRC*HIDX_W-1:0] hart_flat;
  logic [N_SRC*PRIO_W-1:0] prio_flat;
  logic [TGT_W-1:0] tgt_idx;
  logic [CTX_W-1:0] ctx_idx;
  logic [4:0]       off;
  logic             rd, wr, tgt_ok, ctx_ok;
  logic [N_HART-1:0] sel_h, dlv_v, frc_v;
  logic [DATA_W-1:0] top_v [N_HART];
  logic [PRIO_W-1:0] thr_v [N_HART];
  logic [DATA_W-1:0] sel_top, rd_mux;
  logic              sel_dlv, sel_frc;
  logic [PRIO_W-1:0] sel_thr;

  assign rd      = bus_req && !bus_we;
  assign wr      = bus_req && bus_we;
  assign tgt_idx = bus_addr[11:2];
  assign ctx_idx = bus_addr[13:5];
  assign off     = bus_addr[4:0];
  assign tgt_ok  = bus_addr[15:12] == 4'h3 && tgt_idx != '0 && int'(tgt_idx) <= N_SRC;
  assign ctx_ok  = bus_addr[15:14] == 2'b01 && int'(ctx_idx) < N_HART;

  dlv_targets #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_targets (
    .clk(clk), .rst(rst), .wr_en(wr && tgt_ok), .wr_src(tgt_idx[SRC_W-1:0]),
    .wdata(bus_wdata), .hart_flat(hart_flat), .prio_flat(prio_flat));

  for (genvar h = 0; h < N_HART; h++) begin : g_hart
    assign sel_h[h] = ctx_ok && ctx_idx == CTX_W'(h);
    dlv_ctx #(.N_SRC(N_SRC), .SRC_W(SRC_W), .HART_ID(h)) u_ctx (
      .clk(clk), .rst(rst), .pend(src_pend),
      .hart_flat(hart_flat), .prio_flat(prio_flat),
      .wr_dlv(wr && sel_h[h] && off == OFF_DLV),
      .wr_frc(wr && sel_h[h] && off == OFF_FRC),
      .wr_thr(wr && sel_h[h] && off == OFF_THR),
      .wdata(bus_wdata),
      .claim(rd && sel_h[h] && off == OFF_CLM),
      .dlv_o(dlv_v[h]), .frc_o(frc_v[h]), .thr_o(thr_v[h]),
      .top_o(top_v[h]), .irq_o(hart_irq[h]));
  end

  always_comb begin
    sel_top = '0;
    sel_dlv = 1'b0;
    sel_frc = 1'b0;
    sel_thr = '0;
    for (int h = 0; h < N_HART; h++) begin
      if (sel_h[h]) begin
        sel_top = top_v[h];
        sel_dlv = dlv_v[h];
        sel_frc = frc_v[h];
        sel_thr = thr_v[h];
      end
    end
    rd_mux = '0;
    if (tgt_ok) begin
      for (int s = 1; s <= N_SRC; s++) begin
        if (int'(tgt_idx) == s)
          rd_mux = {hart_flat[(s-1)*HIDX_W +: HIDX_W], {(HIDX_LSB-PRIO_W){1'b0}},
                    prio_flat[(s-1)*PRIO_W +: PRIO_W]};
      end
    end else if (ctx_ok) begin
      case (off)
        OFF_DLV:          rd_mux = DATA_W'(sel_dlv);
        OFF_FRC:          rd_mux = DATA_W'(sel_frc);
        OFF_THR:          rd_mux = DATA_W'(sel_thr);
        OFF_TOP, OFF_CLM: rd_mux = sel_top;
        default:          rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      clr_valid  <= 1'b0;
      clr_src    <= '0;
    end else begin
      bus_rvalid <= rd;
      bus_rdata  <= rd ? rd_mux : '0;
      clr_valid  <= rd && ctx_ok && off == OFF_CLM && sel_top != '0;
      clr_src    <= sel_top[ID_LSB +: SRC_W];
    end
  end

  // R6: a clear strobe only travels with returned read data
  p_clr_with_rdata_r6: assert property (@(posedge clk) disable iff (rst)
    clr_valid |-> bus_rvalid);
  // R6: the strobe names a real source
  p_clr_src_range_r6: assert property (@(posedge clk) disable iff (rst)
    clr_valid |-> (clr_src != '0 && int'(clr_src) <= N_SRC));
  // R9: read data appears exactly one cycle after a read request
  p_rvalid_follows_req_r9: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_req && !bus_we));
  // R9: every read request is answered in the next cycle
  p_req_gets_rvalid_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we) |=> bus_rvalid);
endmodule

// File: tb/test_dlv_delivery_ctrl.sv
`timescale 1ns/1ps
module test_dlv_delivery_ctrl;
  localparam int NS = 8;
  localparam int NH = 2;
  localparam int SW = $clog2(NS + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic [NS:1] pend = '0;
  logic [NH-1:0] hart_irq;
  logic clr_valid;
  logic [SW-1:0] clr_src;

  always #2.5 clk = ~clk;

  dlv_delivery_ctrl #(.N_SRC(NS), .N_HART(NH)) i_dlv_delivery_ctrl (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .src_pend(pend), .hart_irq(hart_irq), .clr_valid(clr_valid), .clr_src(clr_src));

  int n_chk = 0, n_fail = 0;
  logic [13:0] t_hart [1:NS];
  logic [7:0]  t_prio [1:NS];
  logic [7:0]  thr [NH];
  logic        dlv [NH];
  logic        frc [NH];
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic [SW-1:0] clr_q [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, e);
    end
  endtask

  function automatic logic [15:0] ta(input int i);
    return 16'h3004 + 16'((i - 1) * 4);
  endfunction
  function automatic logic [15:0] ca(input int h, input int o);
    return 16'h4000 + 16'(h * 32 + o);
  endfunction

  // independent reference of the arbitration and threshold rules
  function automatic logic [31:0] model_top(input int h);
    int best, bp, p;
    best = 0; bp = 256;
    for (int s = 1; s <= NS; s++) begin
      p = (t_prio[s] == 0) ? 1 : int'(t_prio[s]);
      if (pend[s] && int'(t_hart[s]) == h && p < bp) begin
        bp = p; best = s;
      end
    end
    if (best != 0 && (thr[h] == 0 || bp < int'(thr[h])))
      return (32'(best) << 16) | 32'(bp);
    return 32'h0;
  endfunction

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    int h, o, idx;
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    if (a[15:12] == 4'h3) begin
      idx = int'(a[11:2]);
      if (idx >= 1 && idx <= NS) begin
        t_hart[idx] = d[31:18];
        t_prio[idx] = d[7:0];
      end
    end else if (a[15:14] == 2'b01) begin
      h = int'(a[13:5]); o = int'(a[4:0]);
      if (h < NH) begin
        if (o == 0) dlv[h] = d[0];
        if (o == 4) frc[h] = d[0];
        if (o == 8) thr[h] = d[7:0];
      end
    end
  endtask

  // driver: computes the expected word and pushes it to the scoreboard
  task automatic rd(input logic [15:0] a, input string tag, input int raise);
    logic [31:0] e;
    int h, o, idx;
    @(negedge clk);
    if (raise != 0) pend[raise] = 1'b1;
    e = 32'h0;
    if (a[15:12] == 4'h3) begin
      idx = int'(a[11:2]);
      if (idx >= 1 && idx <= NS) e = {t_hart[idx], 10'b0, t_prio[idx]};
    end else if (a[15:14] == 2'b01) begin
      h = int'(a[13:5]); o = int'(a[4:0]);
      if (h < NH) begin
        case (o)
          0:  e = 32'(dlv[h]);
          4:  e = 32'(frc[h]);
          8:  e = 32'(thr[h]);
          24: e = model_top(h);
          28: begin
            e = model_top(h);
            if (e != 0) clr_q.push_back(e[16 +: SW]);
            else frc[h] = 1'b0;
          end
          default: e = 32'h0;
        endcase
      end
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic irq_chk(input logic [NH-1:0] e, input string tag);
    repeat (2) @(negedge clk);
    chk(hart_irq == e, tag, 32'(hart_irq), 32'(e));
  endtask

  // monitor: pops expectations as the design answers
  always @(negedge clk) begin
    logic [31:0] e;
    string t;
    logic [SW-1:0] c;
    if (bus_rvalid === 1'b1) begin
      if (exp_q.size() == 0) chk(1'b0, "R9 read data with no request", bus_rdata, 32'h0);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(bus_rdata == e, t, bus_rdata, e);
      end
    end
    if (clr_valid === 1'b1) begin
      if (clr_q.size() == 0) chk(1'b0, "R7 clear strobe not expected", 32'(clr_src), 32'h0);
      else begin
        c = clr_q.pop_front();
        chk(clr_src == c, "R6 clear strobe source", 32'(clr_src), 32'(c));
        pend[clr_src] = 1'b0;
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int s = 1; s <= NS; s++) begin t_hart[s] = '0; t_prio[s] = 8'd1; end
    for (int h = 0; h < NH; h++) begin thr[h] = '0; dlv[h] = 1'b0; frc[h] = 1'b0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(hart_irq == '0, "R1 hart lines low after reset", 32'(hart_irq), 32'h0);
    rd(ta(1), "R1 target word reset value", 0);
    rd(ca(0, 8), "R1 threshold reset value", 0);
    rd(ca(1, 24), "R1 top reset value", 0);
    // R2 layout and masking
    wr(ta(3), 32'hFFFF_FFFF);
    rd(ta(3), "R2 target word field masking", 0);
    wr(ta(1), 32'h0004_0003); wr(ta(2), 32'h0000_0004); wr(ta(3), 32'h0000_0005);
    wr(ta(4), 32'h0000_0000); wr(ta(5), 32'h0000_0001); wr(ta(6), 32'h0000_0002);
    wr(ta(7), 32'h0004_0007); wr(ta(8), 32'h0000_0009);
    rd(ta(7), "R2 target word readback hart 1", 0);
    // R8 out-of-range and reserved locations
    wr(ta(NS + 1), 32'h0000_0005);
    rd(ta(NS + 1), "R8 source above range reads zero", 0);
    wr(ca(NH, 0), 32'h1);
    rd(ca(NH, 0), "R8 context above range reads zero", 0);
    rd(16'h3000, "R8 reserved word reads zero", 0);
    rd(ca(0, 12), "R8 unused context offset reads zero", 0);
    // R3 selection
    pend[2] = 1'b1; pend[3] = 1'b1;
    rd(ca(0, 24), "R3 lowest priority value wins", 0);
    pend[4] = 1'b1;
    rd(ca(0, 24), "R3 zero priority counts as one", 0);
    pend[5] = 1'b1;
    rd(ca(0, 24), "R3 tie goes to lower source", 0);
    pend[1] = 1'b1; pend[7] = 1'b1;
    rd(ca(1, 24), "R3 routing by hart index", 0);
    pend = '0;
    pend[2] = 1'b1; pend[3] = 1'b1;
    // R4 threshold
    wr(ca(0, 8), 32'd4); rd(ca(0, 24), "R4 equal to threshold blocked", 0);
    wr(ca(0, 8), 32'd5); rd(ca(0, 24), "R4 below threshold admitted", 0);
    wr(ca(0, 8), 32'd1); rd(ca(0, 24), "R4 threshold one blocks all", 0);
    wr(ca(0, 8), 32'd0); rd(ca(0, 24), "R4 threshold zero admits all", 0);
    // R5 hart line
    irq_chk(2'b00, "R5 line low while delivery off");
    wr(ca(0, 0), 32'h1);
    irq_chk(2'b01, "R5 line high with delivery and winner");
    wr(ca(1, 0), 32'h1);
    irq_chk(2'b01, "R5 hart 1 idle without sources");
    wr(ca(1, 4), 32'h1);
    irq_chk(2'b11, "R5 force raises hart 1");
    // R7 empty claim with force only
    rd(ca(1, 28), "R7 empty claim returns zero", 0);
    irq_chk(2'b01, "R7 force gone after empty claim");
    rd(ca(1, 4), "R7 force register cleared", 0);
    // R6 claim loop
    rd(ca(0, 28), "R6 first claim", 0);
    rd(ca(0, 28), "R6 second claim", 0);
    rd(ca(0, 28), "R6 claim drains to zero", 0);
    irq_chk(2'b00, "R6 line drops after drain");
    // R6 claim sampled in the same cycle a more urgent source arrives
    pend[3] = 1'b1;
    rd(ca(0, 28), "R6 claim sees source raised in same cycle", 4);
    rd(ca(0, 28), "R6 older source claimed next", 0);
    // R8 writes to top and claim have no effect
    pend[3] = 1'b1;
    wr(ca(0, 28), 32'hFFFF_FFFF);
    wr(ca(0, 24), 32'h0);
    rd(ca(0, 24), "R8 top unchanged after writes", 0);
    rd(ca(0, 8), "R8 threshold unchanged after writes", 0);
    rd(ca(0, 28), "R6 final claim", 0);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9 every read answered", 32'(exp_q.size()), 32'h0);
    chk(clr_q.size() == 0, "R6 every expected clear seen", 32'(clr_q.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule